// File: doc/BRIEF.md
# LFSR-Position Video Timing Generator

This block produces horizontal sync, vertical sync, a display-enable strobe and line-start and frame-start pulses for a raster display. It works from a set of comparator values that software has already computed and committed. The horizontal and vertical positions are not kept in binary counters. Each position is a 16-bit linear feedback shift register, and every comparison is an equality test against a pre-encoded register state. This keeps the next-state logic of the position to a single XOR level, whatever the raster size.

Software turns each count `n` into the LFSR state reached after `n` steps from all-ones, and writes that state into the matching input. The block then loops lines and frames on its own. A blank-mode input can suppress the picture, or suppress the picture and both syncs together, without disturbing the counters.

Top module: `vtg_lfsr_timing`

## Requirements
- R1: While `rst` is high, every output is inactive (`hsync`, `vsync`, `disp_en`, `line_start`, `frame_start` low with the default active-high sync polarity), and both positions reload to all-ones (count 0).
- R2: On every clock the horizontal position shifts left by one. Its new bit 0 is the XOR of bits 15, 4, 2 and 1 of the old value (`TAP_MASK` default 16'h8016). When the position equals `x_last` it reloads all-ones instead, so a line lasts n+1 clocks when `x_last` holds the state n steps from all-ones. `line_start` repeats with that period.
- R3: The vertical position steps, using the same rule, only in a clock where the horizontal position wraps. It reloads all-ones when it wraps while equal to `y_last`, so a frame has m+1 lines when `y_last` encodes m. `frame_start` pulses once per frame.
- R4: `hsync` is active in clock t+1 exactly when the horizontal count in clock t lies in the half-open range from the count encoded by `hs_on` to the count encoded by `hs_off`.
- R5: `vsync` is active in clock t+1 exactly when the line count in clock t lies in the half-open range from the count encoded by `vs_on` to the count encoded by `vs_off`.
- R6: `disp_en` is high in clock t+1 exactly when, in clock t, all of the following hold: the horizontal count lies in the range [`x_act_start`, `x_act_end`), the line count lies in the range [`y_act_start`, `y_act_end`), and `blank_mode` is 8'h00.
- R7: Any nonzero `blank_mode` in clock t forces `disp_en` low in clock t+1.
- R8: `blank_mode` 8'h01 in clock t forces both syncs inactive in clock t+1. The other nonzero codes (for example 8'h05 and 8'h07) leave the syncs running.
- R9: `line_start` is high in clock t+1 when the horizontal count was 0 in clock t. `frame_start` is high when both counts were 0, and it never occurs without `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| x_act_start | input | POS_W | Encoded first active pixel of a line |
| x_act_end | input | POS_W | Encoded first pixel after the active run |
| y_act_start | input | POS_W | Encoded first active line |
| y_act_end | input | POS_W | Encoded first line after the active run |
| x_last | input | POS_W | Encoded last pixel count of a line |
| y_last | input | POS_W | Encoded last line count of a frame |
| hs_on | input | POS_W | Encoded pixel count where hsync begins |
| hs_off | input | POS_W | Encoded pixel count where hsync ends |
| vs_on | input | POS_W | Encoded line count where vsync begins |
| vs_off | input | POS_W | Encoded line count where vsync ends |
| blank_mode | input | MODE_W | 0x00 normal, 0x01 blank and syncs off, other nonzero blank only |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Active-picture strobe |
| line_start | output | 1 | One-clock pulse at the start of each line |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The bench builds the block with its default 16-bit position and the default tap mask and active-high polarity. It programs three tiny rasters of 24x11, 13x7 and 4x4 clocks, whose encoded values the bench derives from plain counts with its own LFSR stepping function. Such small rasters let every clock of several whole frames be compared against an arithmetic model. The sweep covers windows that end on the wrap count, a vertical sync that begins on line 0, and the one-line-longer frame. Each frame is swept under blank codes 0x00, 0x01, 0x05 and 0x07, with a mid-frame switch between codes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   // window slots compared against a position
   localparam int WIN_HACT  = 0;
   localparam int WIN_HSYNC = 1;
   localparam int WIN_VACT  = 2;
   localparam int WIN_VSYNC = 3;
   localparam int NUM_WIN   = 4;

   // blank-mode codes
   localparam int unsigned BLANK_NONE     = 0;
   localparam int unsigned BLANK_SYNC_OFF = 1;

   // first slot of the vertical group
   localparam int FIRST_V_WIN = WIN_VACT;
endpackage

// File: rtl/vtg_lfsr_reg.sv
module vtg_lfsr_reg #(
   parameter int            W        = 16,
   parameter logic [W-1:0]  TAP_MASK = 16'h8016
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic         reload,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] SEED = '1;

   logic         fb;
   logic [W-1:0] step;

   always_comb begin
      fb   = ^(q & TAP_MASK);
      step = {q[W-2:0], fb};
   end

   always_ff @(posedge clk) begin
      if (rst)         q <= SEED;
      else if (reload) q <= SEED;
      else if (adv)    q <= step;
   end
endmodule

// File: rtl/vtg_win_flag.sv
module vtg_win_flag #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] pos,
   input  logic [W-1:0] set_val,
   input  logic [W-1:0] clr_val,
   output logic         nxt
);
   logic cur;

   // clear has priority so an empty window stays empty
   always_comb begin
      if (pos == clr_val)      nxt = 1'b0;
      else if (pos == set_val) nxt = 1'b1;
      else                     nxt = cur;
   end

   always_ff @(posedge clk) begin
      if (rst) cur <= 1'b0;
      else     cur <= nxt;
   end
endmodule

// File: rtl/vtg_out_stage.sv
module vtg_out_stage
   import vtg_pkg::*;
#(
   parameter int MODE_W        = 8,
   parameter bit SYNC_ACT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hact_n,
   input  logic              vact_n,
   input  logic              hsy_n,
   input  logic              vsy_n,
   input  logic              h_home,
   input  logic              v_home,
   input  logic [MODE_W-1:0] blank_mode,
   output logic              hsync,
   output logic              vsync,
   output logic              disp_en,
   output logic              line_start,
   output logic              frame_start
);
   logic pic_ok, sync_kill;
   logic hs_q, vs_q;

   always_comb begin
      pic_ok    = (blank_mode == MODE_W'(BLANK_NONE));
      sync_kill = (blank_mode == MODE_W'(BLANK_SYNC_OFF));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hs_q        <= 1'b0;
         vs_q        <= 1'b0;
         disp_en     <= 1'b0;
         line_start  <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         hs_q        <= hsy_n & ~sync_kill;
         vs_q        <= vsy_n & ~sync_kill;
         disp_en     <= hact_n & vact_n & pic_ok;
         line_start  <= h_home;
         frame_start <= h_home & v_home;
      end
   end

   generate
      if (SYNC_ACT_HIGH) begin : g_pos_sync
         assign hsync = hs_q;
         assign vsync = vs_q;
      end else begin : g_neg_sync
         assign hsync = ~hs_q;
         assign vsync = ~vs_q;
      end
   endgenerate
endmodule

// File: rtl/vtg_lfsr_timing.sv
module vtg_lfsr_timing
   import vtg_pkg::*;
#(
   parameter int               POS_W         = 16,
   parameter logic [POS_W-1:0] TAP_MASK      = 16'h8016,
   parameter int               MODE_W        = 8,
   parameter bit               SYNC_ACT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [POS_W-1:0]  x_act_start,
   input  logic [POS_W-1:0]  x_act_end,
   input  logic [POS_W-1:0]  y_act_start,
   input  logic [POS_W-1:0]  y_act_end,
   input  logic [POS_W-1:0]  x_last,
   input  logic [POS_W-1:0]  y_last,
   input  logic [POS_W-1:0]  hs_on,
   input  logic [POS_W-1:0]  hs_off,
   input  logic [POS_W-1:0]  vs_on,
   input  logic [POS_W-1:0]  vs_off,
   input  logic [MODE_W-1:0] blank_mode,
   output logic              hsync,
   output logic              vsync,
   output logic              disp_en,
   output logic              line_start,
   output logic              frame_start
);
   localparam logic [POS_W-1:0] SEED = '1;

   generate
      if (POS_W < 4) begin : g_chk_w
         $error("vtg_lfsr_timing: POS_W must be at least 4");
      end
      if (TAP_MASK[POS_W-1] != 1'b1) begin : g_chk_tap
         $error("vtg_lfsr_timing: TAP_MASK must include the top bit");
      end
      if (MODE_W < 1) begin : g_chk_mode
         $error("vtg_lfsr_timing: MODE_W must be at least 1");
      end
   endgenerate

   logic [POS_W-1:0] h_pos, v_pos;
   logic             h_wrap, v_wrap, h_home, v_home;

   always_comb begin
      h_wrap = (h_pos == x_last);
      v_wrap = h_wrap & (v_pos == y_last);
      h_home = (h_pos == SEED);
      v_home = (v_pos == SEED);
   end

   vtg_lfsr_reg #(.W(POS_W), .TAP_MASK(TAP_MASK)) u_hpos (
      .clk(clk), .rst(rst), .adv(1'b1), .reload(h_wrap), .q(h_pos)
   );

   vtg_lfsr_reg #(.W(POS_W), .TAP_MASK(TAP_MASK)) u_vpos (
      .clk(clk), .rst(rst), .adv(h_wrap), .reload(v_wrap), .q(v_pos)
   );

   logic [POS_W-1:0] w_set [NUM_WIN];
   logic [POS_W-1:0] w_clr [NUM_WIN];
   logic [NUM_WIN-1:0] w_nxt;

   always_comb begin
      w_set[WIN_HACT]  = x_act_start;
      w_clr[WIN_HACT]  = x_act_end;
      w_set[WIN_HSYNC] = hs_on;
      w_clr[WIN_HSYNC] = hs_off;
      w_set[WIN_VACT]  = y_act_start;
      w_clr[WIN_VACT]  = y_act_end;
      w_set[WIN_VSYNC] = vs_on;
      w_clr[WIN_VSYNC] = vs_off;
   end

   // horizontal windows watch h_pos, vertical windows watch v_pos
   for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
      if (gi < FIRST_V_WIN) begin : g_h
         vtg_win_flag #(.W(POS_W)) u_flag (
            .clk(clk), .rst(rst), .pos(h_pos),
            .set_val(w_set[gi]), .clr_val(w_clr[gi]), .nxt(w_nxt[gi])
         );
      end else begin : g_v
         vtg_win_flag #(.W(POS_W)) u_flag (
            .clk(clk), .rst(rst), .pos(v_pos),
            .set_val(w_set[gi]), .clr_val(w_clr[gi]), .nxt(w_nxt[gi])
         );
      end
   end

   vtg_out_stage #(.MODE_W(MODE_W), .SYNC_ACT_HIGH(SYNC_ACT_HIGH)) u_out (
      .clk(clk), .rst(rst),
      .hact_n(w_nxt[WIN_HACT]), .vact_n(w_nxt[WIN_VACT]),
      .hsy_n(w_nxt[WIN_HSYNC]), .vsy_n(w_nxt[WIN_VSYNC]),
      .h_home(h_home), .v_home(v_home), .blank_mode(blank_mode),
      .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
      .line_start(line_start), .frame_start(frame_start)
   );
endmodule

// File: rtl/vtg_lfsr_timing_chk.sv
module vtg_lfsr_timing_chk #(
   parameter int               POS_W         = 16,
   parameter logic [POS_W-1:0] TAP_MASK      = 16'h8016,
   parameter int               MODE_W        = 8,
   parameter bit               SYNC_ACT_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [POS_W-1:0]  h_pos,
   input logic [POS_W-1:0]  v_pos,
   input logic [POS_W-1:0]  x_last,
   input logic [MODE_W-1:0] blank_mode,
   input logic              hsync,
   input logic              vsync,
   input logic              disp_en,
   input logic              line_start,
   input logic              frame_start
);
   localparam logic [POS_W-1:0] SEED = '1;
   localparam logic             SYNC_IDLE = ~SYNC_ACT_HIGH;

   // R1: reset holds the horizontal position at count 0
   assert_reset_home_R1: assert property (@(posedge clk)
      $past(rst) |-> h_pos == SEED);

   // R2: a match with the last count sends the position back home
   assert_h_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      $past(h_pos == x_last) |-> h_pos == SEED);

   // R2: a shift register of this kind never reaches the all-zero lockup state
   assert_h_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
      h_pos != '0 && TAP_MASK != '0);

   // R3: the line count moves only when a line ends
   assert_v_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(h_pos == x_last) |-> $stable(v_pos));

   // R7: blanking suppresses the picture strobe
   assert_blank_de_R7: assert property (@(posedge clk) disable iff (rst)
      $past(blank_mode != '0) |-> !disp_en);

   // R8: sync-off code idles both syncs
   assert_blank_sync_R8: assert property (@(posedge clk) disable iff (rst)
      $past(blank_mode == MODE_W'(1)) |-> (hsync == SYNC_IDLE && vsync == SYNC_IDLE));

   // R9: frame start coincides with a line start
   assert_frame_line_R9: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> line_start);

   // R9: line start follows a clock spent at horizontal count 0
   assert_line_origin_R9: assert property (@(posedge clk) disable iff (rst)
      line_start |-> $past(h_pos == SEED));
endmodule

bind vtg_lfsr_timing vtg_lfsr_timing_chk #(
   .POS_W(POS_W), .TAP_MASK(TAP_MASK), .MODE_W(MODE_W), .SYNC_ACT_HIGH(SYNC_ACT_HIGH)
) u_chk (
   .clk(clk), .rst(rst), .h_pos(h_pos), .v_pos(v_pos), .x_last(x_last),
   .blank_mode(blank_mode), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
   .line_start(line_start), .frame_start(frame_start)
);

// File: tb/vtg_lfsr_timing_bench.sv
module vtg_lfsr_timing_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] x_act_start, x_act_end, y_act_start, y_act_end;
   logic [15:0] x_last, y_last, hs_on, hs_off, vs_on, vs_off;
   logic [7:0]  blank_mode = 8'h00;
   logic        hsync, vsync, disp_en, line_start, frame_start;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // binary raster parameters of the current configuration
   int c_hlast, c_vlast, c_xs, c_xe, c_ys, c_ye, c_hs1, c_hs2, c_vs1, c_vs2;
   // model position now, and the position/blank seen at the last edge
   int m_h, m_v, s_h, s_v;
   logic [7:0] s_blank;

   always #(CLK_PERIOD/2) clk = ~clk;

   vtg_lfsr_timing u_vtg_lfsr_timing (
      .clk(clk), .rst(rst),
      .x_act_start(x_act_start), .x_act_end(x_act_end),
      .y_act_start(y_act_start), .y_act_end(y_act_end),
      .x_last(x_last), .y_last(y_last),
      .hs_on(hs_on), .hs_off(hs_off), .vs_on(vs_on), .vs_off(vs_off),
      .blank_mode(blank_mode),
      .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
      .line_start(line_start), .frame_start(frame_start)
   );

   // state after n steps from all-ones: shift left, bit0 = b15^b4^b2^b1
   function automatic logic [15:0] enc(int n);
      logic [15:0] s = 16'hFFFF;
      for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
      return s;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b h=%0d v=%0d blank=%0h t=%0t",
                  tag, act, exp, s_h, s_v, s_blank, $time);
      end
   endtask

   task automatic set_cfg(int ht, int hd, int hss, int hse,
                          int vt, int vd, int vss, int vse);
      c_hlast = ht - 1;  c_vlast = vt;
      c_xs = ht - hss;   c_xe = c_xs + hd;
      c_ys = vt - vss;   c_ye = c_ys + vd;
      c_hs1 = 1;         c_hs2 = hse - hss + 1;
      c_vs1 = 0;         c_vs2 = vse - vss;
      x_act_start = enc(c_xs);  x_act_end = enc(c_xe);
      y_act_start = enc(c_ys);  y_act_end = enc(c_ye);
      x_last = enc(c_hlast);    y_last = enc(c_vlast);
      hs_on = enc(c_hs1); hs_off = enc(c_hs2);
      vs_on = enc(c_vs1); vs_off = enc(c_vs2);
   endtask

   task automatic advance();
      if (m_h == c_hlast) begin
         m_h = 0;
         m_v = (m_v == c_vlast) ? 0 : m_v + 1;
      end else begin
         m_h = m_h + 1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1 hsync", hsync, 1'b0);
         chk("R1 vsync", vsync, 1'b0);
         chk("R1 disp_en", disp_en, 1'b0);
         chk("R1 line_start", line_start, 1'b0);
         chk("R1 frame_start", frame_start, 1'b0);
      end
      rst = 1'b0;
      m_h = 0; m_v = 0;
      s_h = 0; s_v = 0; s_blank = blank_mode;
      advance();
   endtask

   task automatic run(int n, logic [7:0] mode);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         begin
            logic hwin, vwin, hs, vs;
            hwin = (s_h >= c_xs) && (s_h < c_xe);
            vwin = (s_v >= c_ys) && (s_v < c_ye);
            hs   = (s_h >= c_hs1) && (s_h < c_hs2);
            vs   = (s_v >= c_vs1) && (s_v < c_vs2);
            chk((s_blank == 8'h01) ? "R8 hsync" : "R4 hsync", hsync,
                hs && (s_blank != 8'h01));
            chk((s_blank == 8'h01) ? "R8 vsync" : "R5 vsync", vsync,
                vs && (s_blank != 8'h01));
            chk((s_blank != 8'h00) ? "R7 disp_en" : "R6 disp_en", disp_en,
                hwin && vwin && (s_blank == 8'h00));
            chk("R2/R9 line_start", line_start, s_h == 0);
            chk("R3/R9 frame_start", frame_start, (s_h == 0) && (s_v == 0));
         end
         blank_mode = mode;
         s_blank = mode;
         s_h = m_h; s_v = m_v;
         advance();
      end
   endtask

   task automatic sweep(int frame_len);
      run(3 * frame_len, 8'h00);
      run(frame_len, 8'h01);
      run(frame_len, 8'h05);
      run(frame_len, 8'h07);
      run(frame_len / 3, 8'h00);
      run(frame_len / 4, 8'h01);
      run(2 * frame_len, 8'h00);
   endtask

   initial begin
      set_cfg(24, 16, 18, 21, 10, 6, 7, 9);
      do_reset();
      sweep(24 * 11);

      blank_mode = 8'h00;
      set_cfg(13, 8, 9, 11, 6, 3, 4, 5);
      do_reset();
      sweep(13 * 7);

      blank_mode = 8'h00;
      set_cfg(4, 2, 3, 4, 3, 2, 2, 3);
      do_reset();
      sweep(4 * 4);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog (all requirements) act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule